// File: doc/BRIEF.md
# Single-Wire Bus Master Sequencer

This block is the bit-level master for an open-drain serial line that carries both data and timing on a single wire. A command port accepts one operation at a time: a bus reset with presence detection, a write-0 slot, a write-1 slot, or a read slot. The block drives the line low through a drive-enable output and lets a pull-up return it high. It samples the line through a synchronizer. When the operation finishes, it reports the presence flag or the bit it read, together with a one-cycle done strobe.

All timing is counted in microseconds. A prescaler divides the system clock by `CLK_PER_US`, and the prescaler restarts whenever a command is accepted, so every duration is an exact multiple of `CLK_PER_US` cycles.

The reset low time is held to a fixed bound. The default is 490 µs. This keeps reset low time plus line rise time under 960 µs, so the line stays clear for responses from other devices. Byte assembly, device addressing and interrupt handling belong to higher layers.

Top module: `swl_master`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `done`, `result` and `line_drive_low` are all 0.
- R2: The `cmd_op` encoding is 0 = reset, 1 = write-0, 2 = write-1 and 3 = read. A command is accepted on a clock edge where `cmd_valid` is 1 and `busy` is 0. From that edge, `busy` and `line_drive_low` are both 1.
- R3: A reset operation drives the line low for exactly `RST_LOW_US` µs (default 490 µs, inside 480–500 µs). No operation ever holds the line low longer than that.
- R4: After the reset low phase, the line is released for `RST_REL_US` µs (default 490 µs). `result` is 1 if the synchronized line is low `PRES_US` µs (default 70 µs) after the release, and 0 otherwise.
- R5: A write-0 slot drives the line low for `SLOT_US` µs (default 60 µs).
- R6: A write-1 slot drives the line low for `SHORT_LOW_US` µs (default 6 µs), then releases it.
- R7: A read slot drives the line low for `SHORT_LOW_US` µs. `result` equals the synchronized line level `RD_SAMPLE_US` µs (default 15 µs) after the falling edge: 1 when the line is high, 0 when it is low.
- R8: Each write or read operation lasts `SLOT_US + REC_US` µs (default 62 µs). The line is released for at least the final `REC_US` µs, and it is never driven in the cycle where `busy` falls.
- R9: While `busy` is 1, `cmd_valid` and `cmd_op` have no effect. The running operation keeps its timing, and no second operation follows it.
- R10: `done` is 1 for exactly one cycle, at the edge where `busy` falls. `busy` is 0 in that cycle.
- R11: Write operations report `result` = 0 with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Operation code (0 reset, 1 write-0, 2 write-1, 3 read) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation strobe |
| result | output | 1 | Presence flag (reset) or sampled bit (read); 0 for writes |
| line_drive_low | output | 1 | 1 pulls the line low through the open-drain driver |
| line_in | input | 1 | Raw line level, synchronized inside |

## Verification
Several properties are checked on every cycle:
- the line is driven only while busy;
- an accepted command raises busy and the drive together;
- the operation code holds steady while busy;
- done is a single cycle and coincides with busy falling with the line released;
- a counter bounds every low pulse to the reset low length.

Some behaviour can only be shown by the bench scenarios, because it depends on what a device on the line does. This covers the exact low and total durations of each operation, and the presence and read results under each device response. It also covers how commands are ignored mid-operation.

// File: rtl/swl_pkg.sv
package swl_pkg;

    localparam int SWL_US_W = 12;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WR0   = 2'd1,
        OP_WR1   = 2'd2,
        OP_READ  = 2'd3
    } swl_op_e;

    typedef struct packed {
        logic                busy;
        swl_op_e             op;
        logic [SWL_US_W-1:0] us;
        logic                drive;
        logic                result;
        logic                done;
    } swl_seq_s;

endpackage

// File: rtl/swl_tick.sv
module swl_tick #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en) begin
            cnt_d = tick ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/swl_sync.sv
module swl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/swl_seq.sv
module swl_seq
    import swl_pkg::*;
#(
    parameter int RST_LOW_US   = 490,
    parameter int RST_REL_US   = 490,
    parameter int PRES_US      = 70,
    parameter int SLOT_US      = 60,
    parameter int SHORT_LOW_US = 6,
    parameter int RD_SAMPLE_US = 15,
    parameter int REC_US       = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       line_s,
    output logic       accept,
    output logic       busy,
    output logic       done,
    output logic       result,
    output logic       drive_low,
    output logic [1:0] cur_op
);
    localparam int UW = SWL_US_W;
    localparam logic [UW-1:0] T_RST_LOW  = UW'(RST_LOW_US);
    localparam logic [UW-1:0] T_RST_SAMP = UW'(RST_LOW_US + PRES_US);
    localparam logic [UW-1:0] T_RST_END  = UW'(RST_LOW_US + RST_REL_US);
    localparam logic [UW-1:0] T_SLOT_LOW = UW'(SLOT_US);
    localparam logic [UW-1:0] T_SHORT    = UW'(SHORT_LOW_US);
    localparam logic [UW-1:0] T_RD_SAMP  = UW'(RD_SAMPLE_US);
    localparam logic [UW-1:0] T_SLOT_END = UW'(SLOT_US + REC_US);

    swl_seq_s q, d;
    logic [UW-1:0] low_len, samp_at, end_at;
    logic          samp_en;
    logic [UW-1:0] us_inc;

    always_comb begin
        low_len = T_SHORT;
        samp_at = T_RD_SAMP;
        end_at  = T_SLOT_END;
        samp_en = 1'b0;
        unique case (q.op)
            OP_RESET: begin
                low_len = T_RST_LOW;
                samp_at = T_RST_SAMP;
                end_at  = T_RST_END;
                samp_en = 1'b1;
            end
            OP_WR0:  low_len = T_SLOT_LOW;
            OP_WR1:  low_len = T_SHORT;
            OP_READ: samp_en = 1'b1;
            default: ;
        endcase
    end

    assign accept = cmd_valid && !q.busy;
    assign us_inc = q.us + 1'b1;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (accept) begin
            d.busy   = 1'b1;
            d.op     = swl_op_e'(cmd_op);
            d.us     = '0;
            d.drive  = 1'b1;
            d.result = 1'b0;
        end else if (q.busy && tick) begin
            d.us = us_inc;
            if (us_inc >= low_len) d.drive = 1'b0;
            if (samp_en && us_inc == samp_at) begin
                d.result = (q.op == OP_RESET) ? !line_s : line_s;
            end
            if (us_inc == end_at) begin
                d.busy  = 1'b0;
                d.done  = 1'b1;
                d.drive = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.busy   <= 1'b0;
            q.op     <= OP_RESET;
            q.us     <= '0;
            q.drive  <= 1'b0;
            q.result <= 1'b0;
            q.done   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy      = q.busy;
    assign done      = q.done;
    assign result    = q.result;
    assign drive_low = q.drive;
    assign cur_op    = q.op;
endmodule

// File: rtl/swl_master.sv
module swl_master #(
    parameter int CLK_PER_US   = 50,
    parameter int RST_LOW_US   = 490,
    parameter int RST_REL_US   = 490,
    parameter int PRES_US      = 70,
    parameter int SLOT_US      = 60,
    parameter int SHORT_LOW_US = 6,
    parameter int RD_SAMPLE_US = 15,
    parameter int REC_US       = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    output logic       busy,
    output logic       done,
    output logic       result,
    output logic       line_drive_low,
    input  logic       line_in
);
    logic       tick;
    logic       accept;
    logic       line_s;
    logic [1:0] cur_op;

    swl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_in),
        .dout (line_s)
    );

    swl_tick #(.DIV(CLK_PER_US)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (accept),
        .en   (busy),
        .tick (tick)
    );

    swl_seq #(
        .RST_LOW_US  (RST_LOW_US),
        .RST_REL_US  (RST_REL_US),
        .PRES_US     (PRES_US),
        .SLOT_US     (SLOT_US),
        .SHORT_LOW_US(SHORT_LOW_US),
        .RD_SAMPLE_US(RD_SAMPLE_US),
        .REC_US      (REC_US)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .line_s   (line_s),
        .accept   (accept),
        .busy     (busy),
        .done     (done),
        .result   (result),
        .drive_low(line_drive_low),
        .cur_op   (cur_op)
    );
endmodule

// File: rtl/swl_master_chk.sv
module swl_master_chk #(
    parameter int LOW_LIMIT = 24500
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       busy,
    input logic       done,
    input logic       drive_low,
    input logic [1:0] cur_op
);
    int low_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         low_run_q <= 0;
        else if (drive_low) low_run_q <= low_run_q + 1;
        else                low_run_q <= 0;
    end

    assert_drive_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |-> busy);

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> (busy && drive_low));

    assert_low_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_low && low_run_q >= LOW_LIMIT));

    assert_release_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(busy)) |-> !drive_low);

    assert_op_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cur_op));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_with_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
endmodule

bind swl_master swl_master_chk #(.LOW_LIMIT(RST_LOW_US * CLK_PER_US)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .busy     (busy),
    .done     (done),
    .drive_low(line_drive_low),
    .cur_op   (cur_op)
);

// File: tb/sim_swl_master.sv
module sim_swl_master;
    localparam int K = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic       busy, done, result, line_drive_low, line_in;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    bit  pres_en = 1'b0;
    bit  rd_bit = 1'b1;
    logic drv_prev = 1'b0;
    int  low_run = 0;
    int  since_rel = 1000000;
    int  since_fall = 1000000;
    logic slave_pull;

    always #10 clk = ~clk;

    swl_master #(.CLK_PER_US(K)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_op),
        .busy          (busy),
        .done          (done),
        .result        (result),
        .line_drive_low(line_drive_low),
        .line_in       (line_in)
    );

    // device model: presence pulse 30..150 us after a long release, read-0 hold 30 us
    always @(posedge clk) begin
        drv_prev <= line_drive_low;
        low_run  <= line_drive_low ? low_run + 1 : 0;
        if (line_drive_low && !drv_prev) since_fall <= 0;
        else if (since_fall < 1000000)   since_fall <= since_fall + 1;
        if (!line_drive_low && drv_prev && low_run >= 400 * K) since_rel <= 0;
        else if (since_rel < 1000000)                          since_rel <= since_rel + 1;
    end

    assign slave_pull = (pres_en && since_rel >= 30 * K && since_rel < 150 * K)
                     || (!rd_bit && since_fall < 30 * K);
    assign line_in = !(line_drive_low || slave_pull);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input bit poke,
                          output int low_c, output int tot_c, output logic res, output bit first_ok);
        low_c = 0;
        tot_c = 0;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        first_ok  = busy && line_drive_low;
        while (!done && tot_c < 20000) begin
            tot_c++;
            if (line_drive_low) low_c++;
            if (poke && (tot_c == 20 || tot_c == 300)) begin
                cmd_valid = 1'b1;
                cmd_op    = ~op;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        res = result;
        check(tot_c < 20000, "watchdog in operation", tot_c, 0);
    endtask

    function automatic int exp_low(input logic [1:0] op);
        case (op)
            2'd0:    return 490 * K;
            2'd1:    return 60 * K;
            default: return 6 * K;
        endcase
    endfunction

    function automatic int exp_tot(input logic [1:0] op);
        return (op == 2'd0) ? 980 * K : 62 * K;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int   lc, tc;
        logic r;
        bit   f;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(busy == 0, "R1 busy after reset", busy, 0);
        check(done == 0, "R1 done after reset", done, 0);
        check(result == 0, "R1 result after reset", result, 0);
        check(line_drive_low == 0, "R1 drive after reset", line_drive_low, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(busy == 0 && line_drive_low == 0, "R1 idle after release", busy, 0);

        for (int op = 0; op < 4; op++) begin
            for (int rsp = 0; rsp < 2; rsp++) begin
                pres_en = rsp[0];
                rd_bit  = rsp[0];
                repeat (5) @(negedge clk);
                run_op(op[1:0], 1'b0, lc, tc, r, f);
                check(f, "R2 busy and drive on accept", f, 1);
                // R3 R5 R6 R7 low time
                check(lc == exp_low(op[1:0]), "R3/R5/R6/R7 low cycles", lc, exp_low(op[1:0]));
                // R4 R8 total length
                check(tc == exp_tot(op[1:0]), "R4/R8 total cycles", tc, exp_tot(op[1:0]));
                if (op == 0)      check(r == rsp[0], "R4 presence", r, rsp);
                else if (op == 3) check(r == rsp[0], "R7 read bit", r, rsp);
                else              check(r == 0, "R11 write result", r, 0);
                check(busy == 0, "R10 busy low with done", busy, 0);
                @(negedge clk);
                check(done == 0, "R10 done single cycle", done, 0);
            end
        end

        // R9: commands during an operation are ignored
        pres_en = 1'b1;
        rd_bit  = 1'b1;
        for (int op = 0; op < 4; op++) begin
            repeat (5) @(negedge clk);
            run_op(op[1:0], 1'b1, lc, tc, r, f);
            check(lc == exp_low(op[1:0]), "R9 low cycles with poke", lc, exp_low(op[1:0]));
            check(tc == exp_tot(op[1:0]), "R9 total cycles with poke", tc, exp_tot(op[1:0]));
            repeat (3) @(negedge clk);
            check(busy == 0 && line_drive_low == 0, "R9 no follow-on operation", busy, 0);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule